// File: doc/BRIEF.md
# ATA Drive Task-File Register Block

This block is the register file a disk drive presents to its host bus. It holds the 16-bit data port and the 8-bit task-file registers (sector count, sector number, the two cylinder bytes, drive/head select) together with the paired error/features and status/command locations. It also decodes accesses to the control block, where only the alternate status location exists. Every access is classified as legal or illegal from its block, offset, direction and size. A legal access updates or returns the addressed register one cycle later. An illegal access returns an error flag and changes nothing.

The block does not run the drive's command protocol. It emits single-cycle action strobes for status reads, data-port reads, data-port writes and command writes. An external sequencer consumes these strobes and answers through load ports. It can push the next data word, a new status byte or a new error byte. A 32-bit access to the data port is split into two 16-bit transfers. A one-cycle gap lies between them, so the sequencer can supply the next word before the second half is taken.

Top module: `ata_regfile`

## Requirements
- R1: After reset the error register reads 0x01 and every other register (data, sector count, sector number, cylinder low, cylinder high, drive select, status, features and command) holds zero. After reset the block is ready and shows no response.
- R2: Command-block byte offsets 2, 3, 4, 5 and 6 are sector count, sector number, cylinder low, cylinder high and drive select. A byte write there is returned by a later byte read. Every single-phase access gives rsp_valid one cycle after acceptance, with no action strobe.
- R3: Offset 1 is shared. A byte read returns the error register. A byte write loads the features register (seen on feat_o) and leaves the error value unchanged.
- R4: A byte read at command offset 7 returns the status register and pulses act_stat_rd. A byte read at control-block offset 6 returns the same value with no strobe.
- R5: A byte write at command offset 7 loads the command register (seen on cmd_o) and pulses act_cmd_wr together with the response.
- R6: A 16-bit read at offset 0 returns the data register and pulses act_data_rd. A 16-bit write at offset 0 loads the data register (seen on data_o) and pulses act_data_wr.
- R7: A 32-bit read at offset 0 takes the data register as bits 15:0 and pulses act_data_rd. Two cycles later it takes the data register again as bits 31:16. It pulses act_data_rd again and raises rsp_valid. req_ready is low for the two cycles in between.
- R8: A 32-bit write at offset 0 loads bits 15:0 into the data register and pulses act_data_wr. Two cycles later it loads bits 31:16, pulses act_data_wr again and raises rsp_valid.
- R9: These accesses are illegal: a byte read of the data port, any 16- or 32-bit access to offsets 1 to 7, any control-block access other than a byte read at offset 6, and size code 3. An illegal access returns rsp_err=1 and rsp_rdata=0, gives no strobe and changes no register. Size codes are 0 byte, 1 half-word, 2 word and 3 reserved.
- R10: data_load loads data_in into the data register, sts_we loads sts_in into status and err_we loads err_in into error. A host write to the data register in the same cycle wins over data_load.
- R11: A byte write at offset 0 loads the zero-extended byte into the data register and pulses act_data_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Block can accept a request (low during a split transfer) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ctrl | input | 1 | 1 = control block, 0 = command block |
| req_ofs | input | 3 | Register offset within the block |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Access completed |
| rsp_err | output | 1 | Completed access was illegal |
| rsp_rdata | output | 32 | Read data, zero-extended |
| act_stat_rd | output | 1 | Status register was read |
| act_data_rd | output | 1 | A 16-bit data word was read |
| act_data_wr | output | 1 | A data word was written |
| act_cmd_wr | output | 1 | Command register was written |
| data_load | input | 1 | Sequencer supplies the next data word |
| data_in | input | 16 | Next data word |
| sts_we | input | 1 | Sequencer updates status |
| sts_in | input | 8 | New status |
| err_we | input | 1 | Sequencer updates error |
| err_in | input | 8 | New error |
| data_o | output | 16 | Current data register |
| feat_o | output | 8 | Features register |
| cmd_o | output | 8 | Command register |

## Verification
A single-phase access accepted at one rising edge shows its response and strobe right after the next edge. The bench therefore drives each request just after an edge and samples one time unit after the following edge. A 32-bit data access shows its first strobe after the accepting edge and its response two edges later. The bench checks req_ready and data_o at each of those samples. It drives the next data word in the gap cycle, so the upper half must show the new word. Sequencer load ports take effect at the edge where they are high and are read back through a later host access.

// File: rtl/ata_rf_pkg.sv
package ata_rf_pkg;

    localparam int OFS_W = 3;

    // Command-block offsets (the sequencer and host driver depend on them)
    localparam logic [OFS_W-1:0] OFS_DATA   = 3'd0;
    localparam logic [OFS_W-1:0] OFS_ERRFT  = 3'd1;
    localparam logic [OFS_W-1:0] OFS_SECCNT = 3'd2;
    localparam logic [OFS_W-1:0] OFS_SECNUM = 3'd3;
    localparam logic [OFS_W-1:0] OFS_CYLLO  = 3'd4;
    localparam logic [OFS_W-1:0] OFS_CYLHI  = 3'd5;
    localparam logic [OFS_W-1:0] OFS_DRIVE  = 3'd6;
    localparam logic [OFS_W-1:0] OFS_STCMD  = 3'd7;
    // Control-block offset of the alternate status location
    localparam logic [OFS_W-1:0] OFS_ALTST  = 3'd6;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_GAP  = 2'd1,
        PH_HI   = 2'd2
    } phase_e;

    typedef enum logic [3:0] {
        K_NONE,
        K_DATA,
        K_ERRFT,
        K_SECCNT,
        K_SECNUM,
        K_CYLLO,
        K_CYLHI,
        K_DRIVE,
        K_STCMD,
        K_ALTST
    } reg_kind_e;

    typedef struct packed {
        logic      legal;
        logic      split;
        reg_kind_e kind;
    } dec_t;

endpackage

// File: rtl/ata_rf_decode.sv
module ata_rf_decode
    import ata_rf_pkg::*;
(
    input  logic             is_ctrl,
    input  logic             is_write,
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       size,
    output dec_t             dec
);

    logic is_byte;
    logic is_half;
    logic is_word;

    assign is_byte = (size == SZ_BYTE);
    assign is_half = (size == SZ_HALF);
    assign is_word = (size == SZ_WORD);

    always_comb begin
        dec       = '0;
        dec.kind  = K_NONE;
        if (is_ctrl) begin
            dec.kind  = K_ALTST;
            dec.legal = !is_write && (ofs == OFS_ALTST) && is_byte;
        end else begin
            case (ofs)
                OFS_DATA: begin
                    dec.kind  = K_DATA;
                    dec.legal = is_half || is_word || (is_byte && is_write);
                    dec.split = is_word;
                end
                OFS_ERRFT: begin
                    dec.kind  = K_ERRFT;
                    dec.legal = is_byte;
                end
                OFS_SECCNT: begin
                    dec.kind  = K_SECCNT;
                    dec.legal = is_byte;
                end
                OFS_SECNUM: begin
                    dec.kind  = K_SECNUM;
                    dec.legal = is_byte;
                end
                OFS_CYLLO: begin
                    dec.kind  = K_CYLLO;
                    dec.legal = is_byte;
                end
                OFS_CYLHI: begin
                    dec.kind  = K_CYLHI;
                    dec.legal = is_byte;
                end
                OFS_DRIVE: begin
                    dec.kind  = K_DRIVE;
                    dec.legal = is_byte;
                end
                default: begin
                    dec.kind  = K_STCMD;
                    dec.legal = is_byte;
                end
            endcase
        end
        if (!dec.legal) begin
            dec.split = 1'b0;
        end
    end

endmodule

// File: rtl/ata_rf_readmux.sv
module ata_rf_readmux
    import ata_rf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_W  = 8
) (
    input  reg_kind_e         kind,
    input  logic [DATA_W-1:0] data_q,
    input  logic [REG_W-1:0]  err_q,
    input  logic [REG_W-1:0]  seccnt_q,
    input  logic [REG_W-1:0]  secnum_q,
    input  logic [REG_W-1:0]  cyllo_q,
    input  logic [REG_W-1:0]  cylhi_q,
    input  logic [REG_W-1:0]  drive_q,
    input  logic [REG_W-1:0]  status_q,
    output logic [DATA_W-1:0] rd
);

    localparam int PAD_W = DATA_W - REG_W;

    logic [REG_W-1:0] byte_sel;

    always_comb begin
        case (kind)
            K_ERRFT:          byte_sel = err_q;
            K_SECCNT:         byte_sel = seccnt_q;
            K_SECNUM:         byte_sel = secnum_q;
            K_CYLLO:          byte_sel = cyllo_q;
            K_CYLHI:          byte_sel = cylhi_q;
            K_DRIVE:          byte_sel = drive_q;
            K_STCMD, K_ALTST: byte_sel = status_q;
            default:          byte_sel = '0;
        endcase
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd = (kind == K_DATA) ? data_q : {{PAD_W{1'b0}}, byte_sel};
        end else begin : g_nopad
            assign rd = (kind == K_DATA) ? data_q : byte_sel;
        end
    endgenerate

endmodule

// File: rtl/ata_regfile.sv
module ata_regfile
    import ata_rf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic                req_ctrl,
    input  logic [OFS_W-1:0]    req_ofs,
    input  logic [1:0]          req_size,
    input  logic [2*DATA_W-1:0] req_wdata,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [2*DATA_W-1:0] rsp_rdata,
    output logic                act_stat_rd,
    output logic                act_data_rd,
    output logic                act_data_wr,
    output logic                act_cmd_wr,
    input  logic                data_load,
    input  logic [DATA_W-1:0]   data_in,
    input  logic                sts_we,
    input  logic [REG_W-1:0]    sts_in,
    input  logic                err_we,
    input  logic [REG_W-1:0]    err_in,
    output logic [DATA_W-1:0]   data_o,
    output logic [REG_W-1:0]    feat_o,
    output logic [REG_W-1:0]    cmd_o
);

    localparam int BUS_W   = 2 * DATA_W;
    localparam int PAD_W   = DATA_W - REG_W;
    localparam logic [REG_W-1:0] ERR_RST = REG_W'(1);

    typedef struct packed {
        phase_e            phase;
        logic              split_wr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] lo_hold;
        logic [DATA_W-1:0] wr_hi;
        logic [REG_W-1:0]  err;
        logic [REG_W-1:0]  feat;
        logic [REG_W-1:0]  seccnt;
        logic [REG_W-1:0]  secnum;
        logic [REG_W-1:0]  cyllo;
        logic [REG_W-1:0]  cylhi;
        logic [REG_W-1:0]  drive;
        logic [REG_W-1:0]  cmd;
        logic [REG_W-1:0]  status;
        logic              rsp_valid;
        logic              rsp_err;
        logic [BUS_W-1:0]  rsp_rdata;
        logic              stat_rd;
        logic              data_rd;
        logic              data_wr;
        logic              cmd_wr;
    } state_t;

    state_t st_d;
    state_t st_q;

    dec_t              dec;
    logic [DATA_W-1:0] rd_word;
    logic              accept;
    logic [DATA_W-1:0] wr_lo;
    logic [DATA_W-1:0] wr_hi;
    logic [REG_W-1:0]  wr_byte;
    logic [DATA_W-1:0] wr_byte_ext;

    ata_rf_decode u_decode (
        .is_ctrl  (req_ctrl),
        .is_write (req_write),
        .ofs      (req_ofs),
        .size     (req_size),
        .dec      (dec)
    );

    ata_rf_readmux #(
        .DATA_W (DATA_W),
        .REG_W  (REG_W)
    ) u_readmux (
        .kind     (dec.kind),
        .data_q   (st_q.data),
        .err_q    (st_q.err),
        .seccnt_q (st_q.seccnt),
        .secnum_q (st_q.secnum),
        .cyllo_q  (st_q.cyllo),
        .cylhi_q  (st_q.cylhi),
        .drive_q  (st_q.drive),
        .status_q (st_q.status),
        .rd       (rd_word)
    );

    assign req_ready = (st_q.phase == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign wr_lo     = req_wdata[DATA_W-1:0];
    assign wr_hi     = req_wdata[BUS_W-1:DATA_W];
    assign wr_byte   = req_wdata[REG_W-1:0];

    generate
        if (PAD_W > 0) begin : g_wext
            assign wr_byte_ext = {{PAD_W{1'b0}}, wr_byte};
        end else begin : g_wnoext
            assign wr_byte_ext = wr_byte;
        end
    endgenerate

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_err   = 1'b0;
        st_d.stat_rd   = 1'b0;
        st_d.data_rd   = 1'b0;
        st_d.data_wr   = 1'b0;
        st_d.cmd_wr    = 1'b0;

        // Sequencer loads; a host write below overrides the data load
        if (data_load) begin
            st_d.data = data_in;
        end
        if (sts_we) begin
            st_d.status = sts_in;
        end
        if (err_we) begin
            st_d.err = err_in;
        end

        case (st_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    if (!dec.legal) begin
                        st_d.rsp_valid = 1'b1;
                        st_d.rsp_err   = 1'b1;
                        st_d.rsp_rdata = '0;
                    end else if (req_write) begin
                        st_d.rsp_rdata = '0;
                        case (dec.kind)
                            K_DATA: begin
                                st_d.data_wr = 1'b1;
                                if (dec.split) begin
                                    st_d.data     = wr_lo;
                                    st_d.wr_hi    = wr_hi;
                                    st_d.split_wr = 1'b1;
                                    st_d.phase    = PH_GAP;
                                end else begin
                                    st_d.data      = (req_size == SZ_BYTE) ? wr_byte_ext : wr_lo;
                                    st_d.rsp_valid = 1'b1;
                                end
                            end
                            K_ERRFT: begin
                                st_d.feat      = wr_byte;
                                st_d.rsp_valid = 1'b1;
                            end
                            K_SECCNT: begin
                                st_d.seccnt    = wr_byte;
                                st_d.rsp_valid = 1'b1;
                            end
                            K_SECNUM: begin
                                st_d.secnum    = wr_byte;
                                st_d.rsp_valid = 1'b1;
                            end
                            K_CYLLO: begin
                                st_d.cyllo     = wr_byte;
                                st_d.rsp_valid = 1'b1;
                            end
                            K_CYLHI: begin
                                st_d.cylhi     = wr_byte;
                                st_d.rsp_valid = 1'b1;
                            end
                            K_DRIVE: begin
                                st_d.drive     = wr_byte;
                                st_d.rsp_valid = 1'b1;
                            end
                            K_STCMD: begin
                                st_d.cmd       = wr_byte;
                                st_d.cmd_wr    = 1'b1;
                                st_d.rsp_valid = 1'b1;
                            end
                            default: begin
                                st_d.rsp_valid = 1'b1;
                                st_d.rsp_err   = 1'b1;
                            end
                        endcase
                    end else begin
                        if (dec.split) begin
                            st_d.lo_hold  = rd_word;
                            st_d.split_wr = 1'b0;
                            st_d.data_rd  = 1'b1;
                            st_d.phase    = PH_GAP;
                        end else begin
                            st_d.rsp_valid = 1'b1;
                            st_d.rsp_rdata = {{DATA_W{1'b0}}, rd_word};
                            st_d.data_rd   = (dec.kind == K_DATA);
                            st_d.stat_rd   = (dec.kind == K_STCMD);
                        end
                    end
                end
            end
            PH_GAP: begin
                // Sequencer answers the first strobe during this cycle
                st_d.phase = PH_HI;
            end
            default: begin
                st_d.phase     = PH_IDLE;
                st_d.rsp_valid = 1'b1;
                if (st_q.split_wr) begin
                    st_d.data      = st_q.wr_hi;
                    st_d.data_wr   = 1'b1;
                    st_d.rsp_rdata = '0;
                end else begin
                    st_d.data_rd   = 1'b1;
                    st_d.rsp_rdata = {st_q.data, st_q.lo_hold};
                end
                st_d.split_wr = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.err   <= ERR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid   = st_q.rsp_valid;
    assign rsp_err     = st_q.rsp_err;
    assign rsp_rdata   = st_q.rsp_rdata;
    assign act_stat_rd = st_q.stat_rd;
    assign act_data_rd = st_q.data_rd;
    assign act_data_wr = st_q.data_wr;
    assign act_cmd_wr  = st_q.cmd_wr;
    assign data_o      = st_q.data;
    assign feat_o      = st_q.feat;
    assign cmd_o       = st_q.cmd;

endmodule

// File: rtl/ata_rf_chk.sv
module ata_rf_chk #(
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic [BUS_W-1:0] rsp_rdata,
    input logic             act_stat_rd,
    input logic             act_data_rd,
    input logic             act_data_wr,
    input logic             act_cmd_wr
);

    logic [3:0] acts;
    assign acts = {act_stat_rd, act_data_rd, act_data_wr, act_cmd_wr};

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (acts == 4'b0 && rsp_rdata == '0));

    // R4
    act_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acts));

    // R5
    cmd_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_cmd_wr |-> (rsp_valid && !rsp_err));

    // R7
    busy_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !rsp_valid);

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |=> (!req_ready ##1 req_ready));

    // R4
    stat_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_stat_rd |-> (rsp_valid && !rsp_err));

endmodule

bind ata_regfile ata_rf_chk #(.BUS_W(2 * DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .act_stat_rd (act_stat_rd),
    .act_data_rd (act_data_rd),
    .act_data_wr (act_data_wr),
    .act_cmd_wr  (act_cmd_wr)
);

// File: tb/tb_ata_regfile.sv
module tb_ata_regfile;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_ctrl = 1'b0;
    logic [2:0]  req_ofs = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic        act_stat_rd;
    logic        act_data_rd;
    logic        act_data_wr;
    logic        act_cmd_wr;
    logic        data_load = 1'b0;
    logic [15:0] data_in = '0;
    logic        sts_we = 1'b0;
    logic [7:0]  sts_in = '0;
    logic        err_we = 1'b0;
    logic [7:0]  err_in = '0;
    logic [15:0] data_o;
    logic [7:0]  feat_o;
    logic [7:0]  cmd_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ata_regfile dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_ctrl (req_ctrl), .req_ofs (req_ofs), .req_size (req_size),
        .req_wdata (req_wdata), .rsp_valid (rsp_valid), .rsp_err (rsp_err),
        .rsp_rdata (rsp_rdata), .act_stat_rd (act_stat_rd),
        .act_data_rd (act_data_rd), .act_data_wr (act_data_wr),
        .act_cmd_wr (act_cmd_wr), .data_load (data_load), .data_in (data_in),
        .sts_we (sts_we), .sts_in (sts_in), .err_we (err_we), .err_in (err_in),
        .data_o (data_o), .feat_o (feat_o), .cmd_o (cmd_o)
    );

    // Vector: direction, block, offset, size code, write data,
    // expected read data, expected error, expected strobes {stat,drd,dwr,cmd}
    typedef struct packed {
        logic        wr;
        logic        ctl;
        logic [2:0]  ofs;
        logic [1:0]  sz;
        logic [15:0] wd;
        logic [15:0] exp_rd;
        logic        exp_err;
        logic [3:0]  exp_act;
        logic [7:0]  req_no;
    } vec_t;

    localparam int NVEC = 26;
    localparam vec_t VECS [NVEC] = '{
        // R2 task-file byte registers round trip
        '{1'b1, 1'b0, 3'd2, 2'd0, 16'h005A, 16'h0000, 1'b0, 4'b0000, 8'd2},
        '{1'b0, 1'b0, 3'd2, 2'd0, 16'h0000, 16'h005A, 1'b0, 4'b0000, 8'd2},
        '{1'b1, 1'b0, 3'd3, 2'd0, 16'h0033, 16'h0000, 1'b0, 4'b0000, 8'd2},
        '{1'b0, 1'b0, 3'd3, 2'd0, 16'h0000, 16'h0033, 1'b0, 4'b0000, 8'd2},
        '{1'b1, 1'b0, 3'd4, 2'd0, 16'h00C4, 16'h0000, 1'b0, 4'b0000, 8'd2},
        '{1'b1, 1'b0, 3'd5, 2'd0, 16'h007E, 16'h0000, 1'b0, 4'b0000, 8'd2},
        '{1'b0, 1'b0, 3'd4, 2'd0, 16'h0000, 16'h00C4, 1'b0, 4'b0000, 8'd2},
        '{1'b0, 1'b0, 3'd5, 2'd0, 16'h0000, 16'h007E, 1'b0, 4'b0000, 8'd2},
        '{1'b1, 1'b0, 3'd6, 2'd0, 16'h00A0, 16'h0000, 1'b0, 4'b0000, 8'd2},
        '{1'b0, 1'b0, 3'd6, 2'd0, 16'h0000, 16'h00A0, 1'b0, 4'b0000, 8'd2},
        // R3 features write, error read unchanged
        '{1'b1, 1'b0, 3'd1, 2'd0, 16'h0099, 16'h0000, 1'b0, 4'b0000, 8'd3},
        '{1'b0, 1'b0, 3'd1, 2'd0, 16'h0000, 16'h0001, 1'b0, 4'b0000, 8'd3},
        // R5 command write
        '{1'b1, 1'b0, 3'd7, 2'd0, 16'h00EC, 16'h0000, 1'b0, 4'b0001, 8'd5},
        // R4 status read with strobe, alternate status without
        '{1'b0, 1'b0, 3'd7, 2'd0, 16'h0000, 16'h0000, 1'b0, 4'b1000, 8'd4},
        '{1'b0, 1'b1, 3'd6, 2'd0, 16'h0000, 16'h0000, 1'b0, 4'b0000, 8'd4},
        // R6 16-bit data port
        '{1'b1, 1'b0, 3'd0, 2'd1, 16'hBEEF, 16'h0000, 1'b0, 4'b0010, 8'd6},
        '{1'b0, 1'b0, 3'd0, 2'd1, 16'h0000, 16'hBEEF, 1'b0, 4'b0100, 8'd6},
        // R9 illegal accesses
        '{1'b0, 1'b0, 3'd0, 2'd0, 16'h0000, 16'h0000, 1'b1, 4'b0000, 8'd9},
        '{1'b0, 1'b0, 3'd2, 2'd1, 16'h0000, 16'h0000, 1'b1, 4'b0000, 8'd9},
        '{1'b0, 1'b1, 3'd5, 2'd0, 16'h0000, 16'h0000, 1'b1, 4'b0000, 8'd9},
        '{1'b1, 1'b1, 3'd6, 2'd0, 16'h0011, 16'h0000, 1'b1, 4'b0000, 8'd9},
        '{1'b0, 1'b0, 3'd3, 2'd3, 16'h0000, 16'h0000, 1'b1, 4'b0000, 8'd9},
        '{1'b1, 1'b0, 3'd3, 2'd1, 16'h1234, 16'h0000, 1'b1, 4'b0000, 8'd9},
        '{1'b0, 1'b0, 3'd3, 2'd0, 16'h0000, 16'h0033, 1'b0, 4'b0000, 8'd9},
        // R11 byte write to data port
        '{1'b1, 1'b0, 3'd0, 2'd0, 16'h33C7, 16'h0000, 1'b0, 4'b0010, 8'd11},
        '{1'b0, 1'b0, 3'd0, 2'd1, 16'h0000, 16'h00C7, 1'b0, 4'b0100, 8'd11}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Drive one request just after an edge, sample just after the next edge
    task automatic issue(input logic wr, input logic ctl, input logic [2:0] ofs,
                         input logic [1:0] sz, input logic [31:0] wd);
        req_valid = 1'b1;
        req_write = wr;
        req_ctrl  = ctl;
        req_ofs   = ofs;
        req_size  = sz;
        req_wdata = wd;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    function automatic logic [31:0] acts();
        return {28'h0, act_stat_rd, act_data_rd, act_data_wr, act_cmd_wr};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R1 reset state through the ports and register reads
        check("R1 ready", {31'h0, req_ready}, 32'h1);
        check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check("R1 data_o", {16'h0, data_o}, 32'h0);
        check("R1 feat_o/cmd_o", {16'h0, feat_o, cmd_o}, 32'h0);
        issue(1'b0, 1'b0, 3'd1, 2'd0, 32'h0);
        check("R1 error reset", rsp_rdata, 32'h1);
        for (int k = 2; k < 8; k++) begin
            issue(1'b0, 1'b0, 3'(k), 2'd0, 32'h0);
            check("R1 reg reset", rsp_rdata, 32'h0);
        end
        issue(1'b0, 1'b0, 3'd0, 2'd1, 32'h0);
        check("R1 data reset", rsp_rdata, 32'h0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req_no, i);
            issue(VECS[i].wr, VECS[i].ctl, VECS[i].ofs, VECS[i].sz, {16'h0, VECS[i].wd});
            check({tag, " rsp_valid"}, {31'h0, rsp_valid}, 32'h1);
            check({tag, " err"}, {31'h0, rsp_err}, {31'h0, VECS[i].exp_err});
            check({tag, " strobes"}, acts(), {28'h0, VECS[i].exp_act});
            if (!VECS[i].wr) begin
                check({tag, " rdata"}, rsp_rdata, {16'h0, VECS[i].exp_rd});
            end
        end
        check("R3 feat_o", {24'h0, feat_o}, 32'h99);
        check("R5 cmd_o", {24'h0, cmd_o}, 32'hEC);
        check("R11 data_o", {16'h0, data_o}, 32'h00C7);

        // R2 response only one cycle
        @(posedge clk);
        #1;
        check("R2 rsp one cycle", {31'h0, rsp_valid}, 32'h0);

        // R10 sequencer loads
        sts_we = 1'b1; sts_in = 8'h58;
        err_we = 1'b1; err_in = 8'h04;
        @(posedge clk);
        #1;
        sts_we = 1'b0; err_we = 1'b0;
        issue(1'b0, 1'b0, 3'd7, 2'd0, 32'h0);
        check("R10 status load", rsp_rdata, 32'h58);
        issue(1'b0, 1'b1, 3'd6, 2'd0, 32'h0);
        check("R10 alt status", rsp_rdata, 32'h58);
        check("R4 alt no strobe", acts(), 32'h0);
        issue(1'b0, 1'b0, 3'd1, 2'd0, 32'h0);
        check("R10 error load", rsp_rdata, 32'h04);
        data_load = 1'b1; data_in = 16'h1111;
        issue(1'b1, 1'b0, 3'd0, 2'd1, 32'h0000_2222);
        data_load = 1'b0;
        check("R10 host wins", {16'h0, data_o}, 32'h2222);
        data_load = 1'b1; data_in = 16'h4D4D;
        @(posedge clk);
        #1;
        data_load = 1'b0;
        check("R10 data load", {16'h0, data_o}, 32'h4D4D);

        // R7 32-bit read: low = current word, high = word loaded in the gap
        issue(1'b0, 1'b0, 3'd0, 2'd2, 32'h0);
        check("R7 first strobe", acts(), 32'h4);
        check("R7 no rsp yet", {31'h0, rsp_valid}, 32'h0);
        check("R7 busy 1", {31'h0, req_ready}, 32'h0);
        data_load = 1'b1; data_in = 16'hA5C3;
        @(posedge clk);
        #1;
        data_load = 1'b0;
        check("R7 busy 2", {31'h0, req_ready}, 32'h0);
        check("R7 gap no strobe", acts(), 32'h0);
        @(posedge clk);
        #1;
        check("R7 rsp", {31'h0, rsp_valid}, 32'h1);
        check("R7 rdata", rsp_rdata, 32'hA5C3_4D4D);
        check("R7 second strobe", acts(), 32'h4);
        check("R7 ready again", {31'h0, req_ready}, 32'h1);

        // R8 32-bit write: low half first, high half two cycles later
        issue(1'b1, 1'b0, 3'd0, 2'd2, 32'h9876_1357);
        check("R8 low half", {16'h0, data_o}, 32'h1357);
        check("R8 first strobe", acts(), 32'h2);
        check("R8 busy", {31'h0, req_ready}, 32'h0);
        @(posedge clk);
        #1;
        check("R8 held low", {16'h0, data_o}, 32'h1357);
        @(posedge clk);
        #1;
        check("R8 high half", {16'h0, data_o}, 32'h9876);
        check("R8 second strobe", acts(), 32'h2);
        check("R8 rsp", {30'h0, rsp_valid, rsp_err}, 32'h2);

        // R9 illegal 32-bit access to a non-data register leaves it intact
        issue(1'b1, 1'b0, 3'd2, 2'd2, 32'hFFFF_FFFF);
        check("R9 word to reg err", {31'h0, rsp_err}, 32'h1);
        issue(1'b0, 1'b0, 3'd2, 2'd0, 32'h0);
        check("R9 reg intact", rsp_rdata, 32'h5A);

        report();
    end

endmodule